// File: doc/BRIEF.md
# Nested Exception Escalation Unit

This unit sits between the sources that raise processor exceptions and the delivery logic that vectors into a handler. Each raised exception is judged against the exception currently being tracked, which is the last one whose handler has not yet been entered. Depending on the pair, the unit passes the new exception through unchanged, converts it to a double fault (vector 8, error code 0), or declares a triple fault. A triple fault produces a halt code in place of a vector and raises a shutdown request that holds until reset.

Software interrupts skip the pair check. When delivery completes, the consumer pulses a clear strobe, and this empties the tracking register. The tracking register keeps a valid flag separate from the vector, so "nothing tracked" is never confused with a tracked divide error (vector 0). All results are registered. The delivered strobe follows the raise strobe by exactly one clock.

Top module: `exc_escalate`

## Requirements
- R1: Vectors 0, 10, 11, 12 and 13 are contributory, vector 14 is a page fault, vector 8 is a double fault, and every other vector is benign. When no escalation applies, the delivered vector and error code equal the raised ones.
- R2: A contributory exception raised while a contributory exception is tracked is delivered as vector 8 with error code 0.
- R3: A contributory exception or a page fault raised while a page fault is tracked is delivered as vector 8 with error code 0. A benign exception or a raised vector 8 in that state is delivered unchanged.
- R4: Any non-software exception raised while vector 8 is tracked is a triple fault. The delivered vector is the halt code HALT_VEC (default 255), the error code is 0, and shut_o rises in the same cycle as that delivery.
- R5: After a non-software raise, the tracked vector becomes the delivered vector only if that vector is contributory, 14 or 8. A benign result leaves the tracked state as it was.
- R6: A raise with sw_i=1 is delivered with its own vector and error code in every tracked state, never triggers a triple fault, and does not change the tracked state.
- R7: clr_i empties the tracked state. When clr_i and raise_i are both high in one cycle, the clear takes effect first, so the raise is judged against an empty state.
- R8: The empty state escalates nothing: a contributory exception raised while nothing is tracked is delivered unchanged, while the same exception raised with vector 0 tracked becomes vector 8.
- R9: After reset, dlv_o, shut_o, vec_o and err_o are 0. dlv_o is high for exactly the one cycle after each accepted raise and low otherwise. vec_o and err_o hold their values between deliveries.
- R10: Once shut_o is set, it stays set until reset, neither raise_i nor clr_i has any effect, and no further deliveries occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| raise_i | input | 1 | A new exception is raised this cycle |
| vec_i | input | VEC_W | Raised vector number |
| err_i | input | ERR_W | Raised error code |
| sw_i | input | 1 | Raise comes from a software interrupt instruction |
| clr_i | input | 1 | Handler entered; empty the tracked state |
| vec_o | output | VEC_W | Delivered vector, or HALT_VEC on triple fault |
| err_o | output | ERR_W | Delivered error code |
| shut_o | output | 1 | Sticky shutdown request |
| dlv_o | output | 1 | One-cycle delivery strobe |

## Verification
The tracked state cannot be observed directly, so every check of it needs a probe raise. For example, a benign vector that should leave a tracked page fault in place is followed by a contributory raise, and the check is that this raise becomes vector 8. A triple fault needs two tracked steps first: either a raised vector 8, or a contributory pair whose double-fault result becomes the tracked entry. The hardest case to reach is vector 0 tracked, as against nothing tracked. The stimulus reaches it by raising a divide error after a fresh reset and comparing that against a clean reset followed by the same contributory probe.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;
    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2,
        CLS_DOUBLE  = 2'd3
    } exc_cls_e;

    localparam int unsigned VEC_DIVIDE  = 0;
    localparam int unsigned VEC_DOUBLE  = 8;
    localparam int unsigned VEC_CTB_LO  = 10;
    localparam int unsigned VEC_CTB_HI  = 13;
    localparam int unsigned VEC_PAGE    = 14;
endpackage

// File: rtl/exc_class_decode.sv
module exc_class_decode
    import exc_esc_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    output exc_cls_e         cls_o
);
    always_comb begin
        if (vec_i == VEC_W'(VEC_DOUBLE)) begin
            cls_o = CLS_DOUBLE;
        end else if (vec_i == VEC_W'(VEC_PAGE)) begin
            cls_o = CLS_PAGE;
        end else if (vec_i == VEC_W'(VEC_DIVIDE) ||
                     (vec_i >= VEC_W'(VEC_CTB_LO) && vec_i <= VEC_W'(VEC_CTB_HI))) begin
            cls_o = CLS_CONTRIB;
        end else begin
            cls_o = CLS_BENIGN;
        end
    end
endmodule

// File: rtl/exc_escalate_core.sv
module exc_escalate_core
    import exc_esc_pkg::*;
#(
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned ERR_W    = 32,
    parameter int unsigned HALT_VEC = 255
) (
    input  logic [VEC_W-1:0] new_vec_i,
    input  logic [ERR_W-1:0] new_err_i,
    input  logic             sw_i,
    input  exc_cls_e         new_cls_i,
    input  logic             trk_vld_i,
    input  exc_cls_e         trk_cls_i,
    output logic [VEC_W-1:0] res_vec_o,
    output logic [ERR_W-1:0] res_err_o,
    output logic             triple_o,
    output logic             track_upd_o
);
    logic new_ctb;
    logic new_pf;
    logic pair_esc;

    assign new_ctb = (new_cls_i == CLS_CONTRIB);
    assign new_pf  = (new_cls_i == CLS_PAGE);

    // class-pair matrix: contributory/contributory, page/(contributory|page)
    assign pair_esc = trk_vld_i &&
                      (((trk_cls_i == CLS_CONTRIB) && new_ctb) ||
                       ((trk_cls_i == CLS_PAGE) && (new_ctb || new_pf)));

    always_comb begin
        res_vec_o = new_vec_i;
        res_err_o = new_err_i;
        triple_o  = 1'b0;
        if (!sw_i) begin
            if (trk_vld_i && trk_cls_i == CLS_DOUBLE) begin
                triple_o  = 1'b1;
                res_vec_o = VEC_W'(HALT_VEC);
                res_err_o = '0;
            end else if (pair_esc) begin
                res_vec_o = VEC_W'(VEC_DOUBLE);
                res_err_o = '0;
            end
        end
    end

    assign track_upd_o = !sw_i && !triple_o && (pair_esc || new_cls_i != CLS_BENIGN);
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
    import exc_esc_pkg::*;
#(
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned ERR_W    = 32,
    parameter int unsigned HALT_VEC = 255
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             raise_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic             sw_i,
    input  logic             clr_i,
    output logic [VEC_W-1:0] vec_o,
    output logic [ERR_W-1:0] err_o,
    output logic             shut_o,
    output logic             dlv_o
);
    typedef struct packed {
        logic             trk_vld;
        logic [VEC_W-1:0] trk_vec;
        logic [VEC_W-1:0] vec;
        logic [ERR_W-1:0] err;
        logic             dlv;
        logic             shut;
    } esc_state_t;

    esc_state_t st_d, st_q;

    exc_cls_e   new_cls, trk_cls;
    logic       trk_vld_eff;
    logic [VEC_W-1:0] res_vec;
    logic [ERR_W-1:0] res_err;
    logic       res_triple, res_upd;

    // clear is applied before the new raise is judged
    assign trk_vld_eff = st_q.trk_vld && !clr_i;

    exc_class_decode #(.VEC_W(VEC_W)) u_dec_new (
        .vec_i (vec_i),
        .cls_o (new_cls)
    );

    exc_class_decode #(.VEC_W(VEC_W)) u_dec_trk (
        .vec_i (st_q.trk_vec),
        .cls_o (trk_cls)
    );

    exc_escalate_core #(
        .VEC_W    (VEC_W),
        .ERR_W    (ERR_W),
        .HALT_VEC (HALT_VEC)
    ) u_core (
        .new_vec_i   (vec_i),
        .new_err_i   (err_i),
        .sw_i        (sw_i),
        .new_cls_i   (new_cls),
        .trk_vld_i   (trk_vld_eff),
        .trk_cls_i   (trk_cls),
        .res_vec_o   (res_vec),
        .res_err_o   (res_err),
        .triple_o    (res_triple),
        .track_upd_o (res_upd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dlv = 1'b0;
        if (!st_q.shut) begin
            if (clr_i) begin
                st_d.trk_vld = 1'b0;
            end
            if (raise_i) begin
                st_d.dlv = 1'b1;
                st_d.vec = res_vec;
                st_d.err = res_err;
                if (res_triple) begin
                    st_d.shut = 1'b1;
                end
                if (res_upd) begin
                    st_d.trk_vld = 1'b1;
                    st_d.trk_vec = res_vec;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o  = st_q.vec;
    assign err_o  = st_q.err;
    assign shut_o = st_q.shut;
    assign dlv_o  = st_q.dlv;

    p_dlv_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_i && !shut_o) |=> dlv_o);

    p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !raise_i |=> !dlv_o);

    p_shut_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shut_o |=> shut_o);

    p_shut_mute_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shut_o |=> !dlv_o);

    p_triple_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_i && !sw_i && !clr_i && !shut_o && st_q.trk_vld &&
         st_q.trk_vec == VEC_W'(VEC_DOUBLE))
        |=> (shut_o && dlv_o && vec_o == VEC_W'(HALT_VEC) && err_o == '0));

    p_sw_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_i && sw_i && !shut_o)
        |=> (vec_o == $past(vec_i) && err_o == $past(err_i) && !shut_o));
endmodule

// File: tb/sim_exc_escalate.sv
module sim_exc_escalate;
    localparam int VEC_W = 8;
    localparam int ERR_W = 32;
    localparam logic [7:0] HALT = 8'd255;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             raise = 1'b0;
    logic [VEC_W-1:0] vec = '0;
    logic [ERR_W-1:0] err = '0;
    logic             sw = 1'b0;
    logic             clr = 1'b0;
    logic [VEC_W-1:0] vec_o;
    logic [ERR_W-1:0] err_o;
    logic             shut_o;
    logic             dlv_o;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    exc_escalate #(.VEC_W(VEC_W), .ERR_W(ERR_W), .HALT_VEC(255)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .vec_i(vec), .err_i(err),
        .sw_i(sw), .clr_i(clr), .vec_o(vec_o), .err_o(err_o), .shut_o(shut_o),
        .dlv_o(dlv_o)
    );

    // {setup_en, setup_vec, test_vec, sw, exp_vec, exp_err_zero, exp_shut}
    localparam int N = 20;
    localparam logic [27:0] TBL [N] = '{
        // R1: nothing tracked, all classes pass
        {1'b0, 8'd0,  8'd3,  1'b0, 8'd3,  1'b0, 1'b0},
        {1'b0, 8'd0,  8'd13, 1'b0, 8'd13, 1'b0, 1'b0},
        {1'b0, 8'd0,  8'd14, 1'b0, 8'd14, 1'b0, 1'b0},
        {1'b0, 8'd0,  8'd8,  1'b0, 8'd8,  1'b0, 1'b0},
        // R2: contributory tracked
        {1'b1, 8'd13, 8'd3,  1'b0, 8'd3,  1'b0, 1'b0},
        {1'b1, 8'd13, 8'd13, 1'b0, 8'd8,  1'b1, 1'b0},
        {1'b1, 8'd11, 8'd14, 1'b0, 8'd14, 1'b0, 1'b0},
        {1'b1, 8'd12, 8'd8,  1'b0, 8'd8,  1'b0, 1'b0},
        // R3: page fault tracked
        {1'b1, 8'd14, 8'd3,  1'b0, 8'd3,  1'b0, 1'b0},
        {1'b1, 8'd14, 8'd10, 1'b0, 8'd8,  1'b1, 1'b0},
        {1'b1, 8'd14, 8'd14, 1'b0, 8'd8,  1'b1, 1'b0},
        {1'b1, 8'd14, 8'd8,  1'b0, 8'd8,  1'b0, 1'b0},
        // R4: double fault tracked
        {1'b1, 8'd8,  8'd3,  1'b0, HALT,  1'b1, 1'b1},
        {1'b1, 8'd8,  8'd13, 1'b0, HALT,  1'b1, 1'b1},
        {1'b1, 8'd8,  8'd14, 1'b0, HALT,  1'b1, 1'b1},
        {1'b1, 8'd8,  8'd8,  1'b0, HALT,  1'b1, 1'b1},
        // R6: software interrupts bypass
        {1'b1, 8'd8,  8'd13, 1'b1, 8'd13, 1'b0, 1'b0},
        {1'b1, 8'd10, 8'd10, 1'b1, 8'd10, 1'b0, 1'b0},
        // R8: vector 0 tracked escalates; R1: 9 benign, 10 contributory boundary
        {1'b1, 8'd0,  8'd10, 1'b0, 8'd8,  1'b1, 1'b0},
        {1'b1, 8'd9,  8'd10, 1'b0, 8'd10, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; raise = 1'b0; clr = 1'b0; sw = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive for one cycle; on return outputs of that raise are visible
    task automatic fire(input logic [7:0] v, input logic [31:0] e,
                        input logic s, input logic r, input logic c);
        raise = r; vec = v; err = e; sw = s; clr = c;
        @(negedge clk);
        raise = 1'b0; sw = 1'b0; clr = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 reset dlv", 32'(dlv_o), 0);
        chk("R9 reset shut", 32'(shut_o), 0);
        chk("R9 reset vec", 32'(vec_o), 0);
        chk("R9 reset err", err_o, 0);

        for (int i = 0; i < N; i++) begin
            logic [27:0] t;
            logic [31:0] e_in;
            t = TBL[i];
            e_in = 32'h0000_1000 + 32'(i);
            do_reset();
            if (t[27]) fire(t[26:19], 32'h77, 1'b0, 1'b1, 1'b0);
            fire(t[18:11], e_in, t[10], 1'b1, 1'b0);
            chk($sformatf("R1-matrix row %0d dlv", i), 32'(dlv_o), 1);
            chk($sformatf("R2/R3/R4 row %0d vec", i), 32'(vec_o), 32'(t[9:2]));
            chk($sformatf("R2/R3/R4 row %0d err", i), err_o, t[1] ? 32'h0 : e_in);
            chk($sformatf("R4/R6 row %0d shut", i), 32'(shut_o), 32'(t[0]));
        end

        // R5: benign leaves tracked page fault; probe with contributory
        do_reset();
        fire(8'd14, 32'h1, 1'b0, 1'b1, 1'b0);
        fire(8'd3, 32'h2, 1'b0, 1'b1, 1'b0);
        fire(8'd13, 32'h3, 1'b0, 1'b1, 1'b0);
        chk("R5 benign keeps tracked", 32'(vec_o), 8);

        // R5: escalated result becomes tracked, next raise is triple
        do_reset();
        fire(8'd13, 32'h1, 1'b0, 1'b1, 1'b0);
        fire(8'd11, 32'h2, 1'b0, 1'b1, 1'b0);
        fire(8'd3, 32'h3, 1'b0, 1'b1, 1'b0);
        chk("R5 tracked double -> halt", 32'(vec_o), 32'(HALT));
        chk("R4 shut set", 32'(shut_o), 1);

        // R10: once shut, raises and clear ignored
        fire(8'd3, 32'h9, 1'b0, 1'b1, 1'b1);
        chk("R10 no delivery", 32'(dlv_o), 0);
        chk("R10 vec held", 32'(vec_o), 32'(HALT));
        repeat (3) @(negedge clk);
        chk("R10 shut sticky", 32'(shut_o), 1);

        // R6: software int does not update tracked state
        do_reset();
        fire(8'd14, 32'h1, 1'b0, 1'b1, 1'b0);
        fire(8'd13, 32'h5, 1'b1, 1'b1, 1'b0);
        fire(8'd3, 32'h6, 1'b0, 1'b1, 1'b0);
        fire(8'd14, 32'h7, 1'b0, 1'b1, 1'b0);
        chk("R6 sw keeps tracked pf", 32'(vec_o), 8);

        // R7: clear empties tracking
        do_reset();
        fire(8'd13, 32'h1, 1'b0, 1'b1, 1'b0);
        fire(8'd0, 32'h0, 1'b0, 1'b0, 1'b1);
        chk("R9 no dlv on clear only", 32'(dlv_o), 0);
        fire(8'd12, 32'h44, 1'b0, 1'b1, 1'b0);
        chk("R7 after clear vec", 32'(vec_o), 12);
        chk("R7 after clear err", err_o, 32'h44);

        // R7: clear with raise in the same cycle applies first
        do_reset();
        fire(8'd8, 32'h1, 1'b0, 1'b1, 1'b0);
        fire(8'd13, 32'h55, 1'b0, 1'b1, 1'b1);
        chk("R7 same-cycle clear vec", 32'(vec_o), 13);
        chk("R7 same-cycle clear shut", 32'(shut_o), 0);

        // R8: divide error after empty is delivered unchanged
        do_reset();
        fire(8'd0, 32'h66, 1'b0, 1'b1, 1'b0);
        chk("R8 empty + vec0 vec", 32'(vec_o), 0);
        chk("R8 empty + vec0 err", err_o, 32'h66);

        // R9: strobe lasts one cycle, outputs hold
        @(negedge clk);
        chk("R9 dlv single cycle", 32'(dlv_o), 0);
        chk("R9 err held", err_o, 32'h66);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule